// File: doc/BRIEF.md
# Reset Cause Recorder and Reset Output Driver

This block gathers the four ways a chip can be reset: power arriving, the external reset pin, a watchdog expiry and the software reset instruction. It merges them into one internal reset that is stretched by a fixed hold time. It also records, in a readable byte, which of these causes started the most recent reset. The same byte carries an enable for a reset output pin. When that enable is set, the pin drops low for resets that come from inside the chip. When it is clear, the pin acts as an ordinary software-driven output.

The block also supplies the reset value of the watchdog control register, because that value depends on the cause. At power-up the reset output gives a bounded low pulse of `PUP_CYC` clocks. `PUP_CYC` must be kept between 0 and 258. The external pin has no influence on that pulse.

The sequencing is a three-state machine:
- **RUN**: no reset is active.
- **ACTIVE**: a cause is currently present. Power-up forces this state asynchronously.
- **STRETCH**: the hold countdown after the last cause has gone.

The transitions are:
- RUN→ACTIVE on any cause.
- ACTIVE→ACTIVE while a cause persists.
- ACTIVE→STRETCH when all causes are gone.
- STRETCH→ACTIVE on a new cause.
- STRETCH→RUN when the countdown reaches zero.

The `ext_rst_n`, `wdt_trip` and `sw_trip` inputs are assumed synchronous to `clk`. `por_n` asserts asynchronously and releases synchronously.

Top module: `reset_source_ctrl`

## Requirements
- R1: While `por_n` is low, and after it rises until the reset ends, `sys_rst_n` is 0 and `rst_cause` reads 8'h08 (bit 3 = power-up, enable bit 7 = 0).
- R2: Bits 3:0 of `rst_cause` are always exactly one-hot, and bits 6:4 are always 0. The cause bits are: bit 0 software, bit 1 watchdog, bit 2 external pin, bit 3 power-up.
- R3: When several causes are sampled on the same edge, the recorded cause follows the priority external pin, then watchdog, then software.
- R4: The cause is captured only on the edge that leaves RUN. Causes arriving during an ongoing reset extend it but leave `rst_cause[3:0]` unchanged.
- R5: `sys_rst_n` falls after the first edge that samples a cause. It rises after edge k+HOLD_CYC+1, where k is the last edge that sampled a cause, so it is low for HOLD_CYC+1 cycles after a one-cycle cause.
- R6: `wdctl_init` is 8'hE6 when the recorded cause is the watchdog, and 8'hE4 otherwise.
- R7: `rst_cause[7]` is written from `rout_en_wdata` by `rout_en_wr` only while `sys_rst_n` is 1. It is cleared only by power-up and survives all other resets.
- R8: With bit 7 set and a watchdog or software cause recorded, `rst_out_n` is low while `sys_rst_n` is low and for exactly one cycle after it rises. With bit 7 clear, such resets leave `rst_out_n` high.
- R9: Resets caused by the external pin never drive `rst_out_n` low, whatever the enable.
- R10: After `por_n` rises, `rst_out_n` is low for exactly PUP_CYC edges and then goes high, even with `ext_rst_n` held low.
- R11: With bit 7 clear, `rst_out_n` equals `!gpio_low` once the power-up pulse is over, and `gpio_low` never affects `sys_rst_n`. With bit 7 set, `gpio_low` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-up reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, synchronised |
| wdt_trip | input | 1 | Watchdog expiry pulse |
| sw_trip | input | 1 | Software reset instruction pulse |
| rout_en_wr | input | 1 | Write strobe for the reset-output enable bit |
| rout_en_wdata | input | 1 | Value written to enable bit 7 |
| gpio_low | input | 1 | Software request to drive the pin low in GPIO mode |
| sys_rst_n | output | 1 | Internal chip reset, active low |
| rst_cause | output | 8 | Bit 7 output enable, bits 3:0 one-hot last cause |
| wdctl_init | output | 8 | Reset value for the watchdog control register |
| rst_out_n | output | 1 | Reset output / GPIO pin level |

## Verification
A cause sampled at a rising edge shows on `sys_rst_n` and `rst_cause` right after that edge, with one register on the way. The release comes HOLD_CYC+1 edges after the last sampled cause. `rst_out_n` lags the release by one more edge. `gpio_low` reaches `rst_out_n` in the same cycle. The bench drives inputs 1 ns after each falling edge and compares every output against a behavioural model at the falling edge. The model counts quiet edges and power-up edges with integers. Directed checks measure the low time of `sys_rst_n` and the one-cycle tail of `rst_out_n` by counting falling edges.

// File: rtl/reset_src_pkg.sv
package reset_src_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_STRETCH = 2'd2
    } rst_state_e;

    localparam int CAUSE_N   = 4;
    localparam int CAUSE_SW  = 0;
    localparam int CAUSE_WDT = 1;
    localparam int CAUSE_EXT = 2;
    localparam int CAUSE_PWR = 3;

    localparam logic [7:0] WDCTL_AFTER_WDT   = 8'hE6;
    localparam logic [7:0] WDCTL_AFTER_OTHER = 8'hE4;

endpackage

// File: rtl/reset_cause_arb.sv
module reset_cause_arb
    import reset_src_pkg::*;
(
    input  logic               ext_low,
    input  logic               wdt_hit,
    input  logic               sw_hit,
    output logic               any_cause,
    output logic [CAUSE_N-1:0] cause_vec
);
    always_comb begin
        cause_vec = '0;
        if (ext_low)      cause_vec[CAUSE_EXT] = 1'b1;
        else if (wdt_hit) cause_vec[CAUSE_WDT] = 1'b1;
        else if (sw_hit)  cause_vec[CAUSE_SW]  = 1'b1;
        any_cause = ext_low | wdt_hit | sw_hit;
    end
endmodule

// File: rtl/reset_seq_fsm.sv
module reset_seq_fsm
    import reset_src_pkg::*;
#(
    parameter int HOLD_CYC = 8
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               any_cause,
    input  logic [CAUSE_N-1:0] cause_vec,
    output logic               in_reset,
    output logic [CAUSE_N-1:0] cause_q
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC - 1);

    rst_state_e        state, state_nx;
    logic [CNT_W-1:0]  hold_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_ACTIVE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:     state_nx = any_cause ? ST_ACTIVE : ST_RUN;
            ST_ACTIVE:  state_nx = any_cause ? ST_ACTIVE : ST_STRETCH;
            ST_STRETCH: begin
                if (any_cause)          state_nx = ST_ACTIVE;
                else if (hold_cnt == 0) state_nx = ST_RUN;
                else                    state_nx = ST_STRETCH;
            end
            default:    state_nx = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hold_cnt <= CNT_LOAD;
        end else if (state_nx == ST_STRETCH && state != ST_STRETCH) begin
            hold_cnt <= CNT_LOAD;
        end else if (state == ST_STRETCH && hold_cnt != 0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_q <= CAUSE_N'(1) << CAUSE_PWR;
        end else if (state == ST_RUN && any_cause) begin
            cause_q <= cause_vec;
        end
    end

    always_comb begin
        in_reset = (state != ST_RUN);
    end
endmodule

// File: rtl/pwrup_pulse.sv
module pwrup_pulse #(
    parameter int PUP_CYC = 20
) (
    input  logic clk,
    input  logic por_n,
    output logic pulse_on
);
    localparam int CNT_W = $clog2(PUP_CYC + 2);

    logic [CNT_W-1:0] left;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)         left <= CNT_W'(PUP_CYC);
        else if (left != 0) left <= left - 1'b1;
    end

    assign pulse_on = (left != 0);
endmodule

// File: rtl/reset_source_ctrl.sv
module reset_source_ctrl
    import reset_src_pkg::*;
#(
    parameter int HOLD_CYC = 8,
    parameter int PUP_CYC  = 20
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ext_rst_n,
    input  logic       wdt_trip,
    input  logic       sw_trip,
    input  logic       rout_en_wr,
    input  logic       rout_en_wdata,
    input  logic       gpio_low,
    output logic       sys_rst_n,
    output logic [7:0] rst_cause,
    output logic [7:0] wdctl_init,
    output logic       rst_out_n
);
    logic               any_cause;
    logic [CAUSE_N-1:0] cause_vec;
    logic [CAUSE_N-1:0] cause_q;
    logic               in_reset;
    logic               in_reset_q;
    logic               out_en;
    logic               pup_on;
    logic               internal_src;

    reset_cause_arb u_arb (
        .ext_low   (!ext_rst_n),
        .wdt_hit   (wdt_trip),
        .sw_hit    (sw_trip),
        .any_cause (any_cause),
        .cause_vec (cause_vec)
    );

    reset_seq_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .any_cause (any_cause),
        .cause_vec (cause_vec),
        .in_reset  (in_reset),
        .cause_q   (cause_q)
    );

    pwrup_pulse #(.PUP_CYC(PUP_CYC)) u_pup (
        .clk      (clk),
        .por_n    (por_n),
        .pulse_on (pup_on)
    );

    // enable bit survives every reset but power-up; writable only in RUN
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            out_en     <= 1'b0;
            in_reset_q <= 1'b1;
        end else begin
            in_reset_q <= in_reset;
            if (rout_en_wr && !in_reset) out_en <= rout_en_wdata;
        end
    end

    assign internal_src = cause_q[CAUSE_WDT] | cause_q[CAUSE_SW];

    always_comb begin
        sys_rst_n  = !in_reset;
        rst_cause  = {out_en, 3'b000, cause_q};
        wdctl_init = cause_q[CAUSE_WDT] ? WDCTL_AFTER_WDT : WDCTL_AFTER_OTHER;
        if (pup_on)      rst_out_n = 1'b0;
        else if (out_en) rst_out_n = !(internal_src && (in_reset || in_reset_q));
        else             rst_out_n = !gpio_low;
    end
endmodule

// File: rtl/reset_source_ctrl_chk.sv
module reset_source_ctrl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       ext_rst_n,
    input logic       wdt_trip,
    input logic       sw_trip,
    input logic       sys_rst_n,
    input logic [7:0] rst_cause,
    input logic [7:0] wdctl_init,
    input logic       rst_out_n,
    input logic       pup_on
);
    p_onehot_r2: assert property (@(posedge clk) disable iff (!por_n)
        ($onehot(rst_cause[3:0]) && rst_cause[6:4] == 3'b000));

    p_entry_r5: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && (!ext_rst_n || wdt_trip || sw_trip)) |=> !sys_rst_n);

    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && ext_rst_n && !wdt_trip && !sw_trip) |=> sys_rst_n);

    p_cause_held_r4: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && !$past(sys_rst_n)) |-> $stable(rst_cause[3:0]));

    p_wdctl_wdt_r6: assert property (@(posedge clk) disable iff (!por_n)
        rst_cause[1] |-> (wdctl_init == 8'hE6));

    p_wdctl_other_r6: assert property (@(posedge clk) disable iff (!por_n)
        !rst_cause[1] |-> (wdctl_init == 8'hE4));

    p_tail_r8: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(sys_rst_n) && rst_cause[7] && (rst_cause[1] || rst_cause[0])) |-> !rst_out_n);

    p_idle_high_r8: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && $past(sys_rst_n) && rst_cause[7] && !pup_on) |-> rst_out_n);

    p_ext_quiet_r9: assert property (@(posedge clk) disable iff (!por_n)
        (rst_cause[2] && rst_cause[7] && !pup_on) |-> rst_out_n);

    p_pup_low_r10: assert property (@(posedge clk) disable iff (!por_n)
        pup_on |-> !rst_out_n);
endmodule

bind reset_source_ctrl reset_source_ctrl_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .ext_rst_n  (ext_rst_n),
    .wdt_trip   (wdt_trip),
    .sw_trip    (sw_trip),
    .sys_rst_n  (sys_rst_n),
    .rst_cause  (rst_cause),
    .wdctl_init (wdctl_init),
    .rst_out_n  (rst_out_n),
    .pup_on     (pup_on)
);

// File: tb/reset_source_ctrl_tb.sv
`timescale 1ns/1ps
module reset_source_ctrl_tb;
    localparam int H   = 8;
    localparam int PUP = 20;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ext_rst_n = 1'b1;
    logic wdt_trip = 1'b0;
    logic sw_trip = 1'b0;
    logic rout_en_wr = 1'b0;
    logic rout_en_wdata = 1'b0;
    logic gpio_low = 1'b0;
    logic       sys_rst_n;
    logic [7:0] rst_cause;
    logic [7:0] wdctl_init;
    logic       rst_out_n;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit started = 1'b0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    reset_source_ctrl #(.HOLD_CYC(H), .PUP_CYC(PUP)) u_dut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdt_trip(wdt_trip),
        .sw_trip(sw_trip), .rout_en_wr(rout_en_wr), .rout_en_wdata(rout_en_wdata),
        .gpio_low(gpio_low), .sys_rst_n(sys_rst_n), .rst_cause(rst_cause),
        .wdctl_init(wdctl_init), .rst_out_n(rst_out_n)
    );

    // behavioural reference: quiet-edge counting, power-up edge counting
    bit       m_inres, m_inres_q, m_en;
    logic [3:0] m_cause;
    int       m_quiet, m_pup_edges;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_inres = 1; m_inres_q = 1; m_en = 0; m_quiet = 0;
            m_cause = 4'b1000; m_pup_edges = 0;
        end else begin
            bit old;
            old = m_inres;
            if (rout_en_wr && !old) m_en = rout_en_wdata;
            if (!ext_rst_n || wdt_trip || sw_trip) begin
                if (!old) m_cause = !ext_rst_n ? 4'b0100 : (wdt_trip ? 4'b0010 : 4'b0001);
                m_inres = 1; m_quiet = 0;
            end else if (old) begin
                m_quiet++;
                if (m_quiet > H) m_inres = 0;
            end
            m_inres_q = old;
            if (m_pup_edges < PUP) m_pup_edges++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            bit exp_rst_n, exp_out_n, internal;
            logic [7:0] exp_cause, exp_wd;
            exp_rst_n = !m_inres;
            exp_cause = {m_en, 3'b000, m_cause};
            exp_wd    = m_cause[1] ? 8'hE6 : 8'hE4;
            internal  = m_cause[1] | m_cause[0];
            if (m_pup_edges < PUP) exp_out_n = 0;
            else if (m_en)         exp_out_n = !(internal && (m_inres || m_inres_q));
            else                   exp_out_n = !gpio_low;
            check(sys_rst_n == exp_rst_n, "R5 sys_rst_n", sys_rst_n, exp_rst_n);
            check(rst_cause == exp_cause, "R2 R3 R4 R7 rst_cause", rst_cause, exp_cause);
            check(wdctl_init == exp_wd, "R6 wdctl_init", wdctl_init, exp_wd);
            check(rst_out_n == exp_out_n, "R8 R9 R10 R11 rst_out_n", rst_out_n, exp_out_n);
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_run();
        while (!sys_rst_n) tick();
        tick(); tick();
    endtask

    task automatic pulse(input int which);
        tick();
        if (which == 0) sw_trip = 1; else wdt_trip = 1;
        tick();
        sw_trip = 0; wdt_trip = 0;
    endtask

    task automatic set_en(input bit v);
        tick(); rout_en_wr = 1; rout_en_wdata = v;
        tick(); rout_en_wr = 0;
    endtask

    initial begin
        int n;
        ticks(3);
        check(sys_rst_n == 0, "R1 in por", sys_rst_n, 0);
        check(rst_cause == 8'h08, "R1 cause", rst_cause, 8'h08);
        check(rst_out_n == 0, "R10 pulse in por", rst_out_n, 0);
        por_n = 1; started = 1;
        // R10: pulse ends after PUP edges; R1 power-up hold
        ticks(PUP + 2);
        check(rst_out_n == 1, "R10 pulse over", rst_out_n, 1);
        check(rst_cause == 8'h08, "R1 cause after", rst_cause, 8'h08);

        // second power-up with external pin held low: pulse unaffected
        started = 0; por_n = 0; ext_rst_n = 0; tick(); por_n = 1; started = 1;
        ticks(PUP + 2);
        check(rst_out_n == 1 && sys_rst_n == 0, "R10 ext pin ignored", {rst_out_n, sys_rst_n}, 2'b10);
        ext_rst_n = 1;
        wait_run();

        set_en(1);
        check(rst_cause == 8'h88, "R7 enable set", rst_cause, 8'h88);
        pulse(0);
        check(rst_cause == 8'h81, "R3 sw cause", rst_cause, 8'h81);
        check(wdctl_init == 8'hE4, "R6 non-wdt", wdctl_init, 8'hE4);
        n = 0;
        while (!sys_rst_n) begin n++; tick(); end
        check(n == H + 1, "R5 hold length", n, H + 1);
        check(rst_out_n == 0, "R8 one-cycle tail", rst_out_n, 0);
        tick();
        check(rst_out_n == 1, "R8 tail end", rst_out_n, 1);
        ticks(2);

        pulse(1);
        check(rst_cause == 8'h82 && wdctl_init == 8'hE6, "R6 wdt value", wdctl_init, 8'hE6);
        // R7: write attempt during reset ignored
        rout_en_wr = 1; rout_en_wdata = 0; tick(); rout_en_wr = 0;
        wait_run();
        check(rst_cause[7] == 1, "R7 write in reset ignored", rst_cause[7], 1);

        // R9: external pin reset with enable set
        tick(); ext_rst_n = 0; ticks(4);
        check(rst_out_n == 1 && rst_cause == 8'h84, "R9 ext quiet", {rst_out_n, rst_cause}, 9'h184);
        ext_rst_n = 1; wait_run();

        // R3 priority on simultaneous causes
        tick(); ext_rst_n = 0; wdt_trip = 1; sw_trip = 1; tick();
        ext_rst_n = 1; wdt_trip = 0; sw_trip = 0;
        check(rst_cause[3:0] == 4'b0100, "R3 ext wins", rst_cause[3:0], 4'b0100);
        wait_run();
        tick(); wdt_trip = 1; sw_trip = 1; tick(); wdt_trip = 0; sw_trip = 0;
        check(rst_cause[3:0] == 4'b0010, "R3 wdt over sw", rst_cause[3:0], 4'b0010);
        wait_run();

        // R4: a cause during reset extends it, keeps the cause
        pulse(0); ticks(3);
        wdt_trip = 1; tick(); wdt_trip = 0;
        check(rst_cause[3:0] == 4'b0001 && sys_rst_n == 0, "R4 cause kept", rst_cause[3:0], 4'b0001);
        wait_run();

        // R11 GPIO mode and ignore when enabled
        gpio_low = 1; #0.5;
        check(rst_out_n == 1, "R11 gpio ignored when enabled", rst_out_n, 1);
        gpio_low = 0;
        set_en(0);
        gpio_low = 1; #0.5;
        check(rst_out_n == 0, "R11 gpio drives low", rst_out_n, 0);
        ticks(4);
        check(sys_rst_n == 1, "R11 gpio no reset", sys_rst_n, 1);
        gpio_low = 0; #0.5;
        check(rst_out_n == 1, "R11 gpio release", rst_out_n, 1);

        // R8: enable clear, watchdog reset keeps pin high
        pulse(1); ticks(2);
        check(rst_out_n == 1 && rst_cause == 8'h02, "R8 disabled", {rst_out_n, rst_cause}, 9'h102);
        wait_run();
        check(sys_rst_n == 1, "R5 back to run", sys_rst_n, 1);
        finish_run();
    end
endmodule